// File: doc/BRIEF.md
# UART Receive Buffer Status Controller

This block sits between a UART receive deserializer and a receive buffer of fixed length. Each received character comes in with a wake (ninth) bit and with framing and parity error flags. Line-level events arrive on their own inputs: one idle period, a break, and a receiver overrun. The block writes data characters into consecutive buffer slots through a byte-write port. It decides when the current buffer ends. When a buffer ends, it reports a status word and the byte count on a close strobe that lasts one cycle. It can also raise a receive event on that strobe.

A buffer ends for one of these reasons: its last slot fills, a programmed control character arrives, a character with an error arrives, a break is seen, or a programmable run of idle periods passes. Two multidrop schemes are built in. In the manual scheme, a wake character starts a new buffer and the buffer is marked as beginning with an address byte. In the automatic scheme, characters are thrown away until a wake character equals one of two address registers. That address byte is never stored, and the status of each following buffer records which register matched.

The controller is one state machine with three states. In ST_HUNT it waits for an address; this applies to automatic mode only, and in the other modes it behaves like ST_EMPTY. ST_EMPTY is an open buffer with no bytes. ST_FILL is an open buffer holding at least one byte. The transitions are:
- T_ADDR_HIT: ST_HUNT to ST_EMPTY, on a matching address.
- T_FIRST_BYTE: ST_EMPTY or ST_HUNT to ST_FILL, on the first stored byte.
- T_CLOSE: ST_FILL to ST_EMPTY, when the buffer closes.
- T_ADDR_MISS: to ST_HUNT, on a wake character that matches no address in automatic mode.
- T_BREAK_HUNT: to ST_HUNT, on a break in automatic mode.
- T_REHIT: ST_FILL to ST_EMPTY, on a matching wake character.

Top module: `uart_rxbuf_ctl`

## Requirements
- R1: After reset, no write, close or event strobe is active. In modes 00, 01 and 10 the first character received is stored at slot 0. In mode 11 the block starts out hunting for an address.
- R2: Each stored character appears on the write port with wr_idx equal to its position in the current buffer. The position starts at 0 and resets to 0 when a buffer closes.
- R3: Storing into the last slot (BUF_LEN) closes the buffer with cls_count = BUF_LEN. If no other cause applies, the status is 0x00.
- R4: When cfg_ctrl_en is 1 and a data character equals cfg_ctrl_char, the character is stored as the last byte and the buffer closes with status bit 7 (control) set.
- R5: A character with a framing error or a parity error is stored as the last byte and the buffer closes. A framing error sets status bit 2; a parity error sets status bit 1.
- R6: After cfg_max_idle consecutive idle ticks with no character in between, a non-empty buffer closes with status bit 4 (idle) set. An empty buffer never closes on idle, and a cfg_max_idle of 0 turns idle closure off.
- R7: A break closes the open buffer with status bit 3 set, even when the buffer is empty (count 0). In mode 11 the block then returns to hunting.
- R8: An overrun sets status bit 0 on the next buffer close. The flag is clear again for the buffer after that. An overrun seen while hunting is ignored.
- R9: In mode 01, a wake character first closes a non-empty buffer. The wake character is then stored at slot 0 of a new buffer, and that new buffer closes with status bit 6 (address) set.
- R10: In mode 11, while hunting, no character is stored. A wake character equal to cfg_addr1 or cfg_addr2 ends the hunt. Address characters are never written.
- R11: In mode 11, every buffer closed while addressed has status bit 6 set. Status bit 5 is 1 if cfg_addr1 matched and 0 if cfg_addr2 matched. Bit 5 is never set without bit 6.
- R12: In mode 11, a wake character received while addressed closes a non-empty buffer with its old status. The block then stays addressed with the new match if the address matches, and goes back to hunting if it does not.
- R13: rx_event pulses together with cls_valid when cfg_int_en is 1 in the closing cycle. Otherwise rx_event stays low.
- R14: The write and close strobes for an input event appear one clock after that event is sampled. At most one of chr_valid, idle_tick and brk_det is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chr_valid | input | 1 | Received character present this cycle |
| chr_data | input | DATA_W | Received character |
| chr_wake | input | 1 | Ninth (wake/address) bit of the character |
| chr_ferr | input | 1 | Stop bit missing on this character |
| chr_perr | input | 1 | Parity mismatch on this character |
| idle_tick | input | 1 | One idle period completed on the line |
| brk_det | input | 1 | Break detected |
| ovr_det | input | 1 | Receiver overrun detected |
| cfg_mode | input | 2 | 00/10 plain, 01 manual multidrop, 11 automatic multidrop |
| cfg_int_en | input | 1 | Raise rx_event on buffer close |
| cfg_ctrl_en | input | 1 | Enable control-character matching |
| cfg_ctrl_char | input | DATA_W | Control character value |
| cfg_addr1 | input | DATA_W | First multidrop address |
| cfg_addr2 | input | DATA_W | Second multidrop address |
| cfg_max_idle | input | IDLE_W | Idle ticks before closure (0 disables) |
| wr_valid | output | 1 | Byte write strobe |
| wr_idx | output | clog2(BUF_LEN) | Slot index of the byte |
| wr_data | output | DATA_W | Byte written |
| cls_valid | output | 1 | Buffer close strobe |
| cls_status | output | 8 | [7] control, [6] address, [5] match first, [4] idle, [3] break, [2] framing, [1] parity, [0] overrun |
| cls_count | output | clog2(BUF_LEN+1) | Bytes in the closed buffer |
| rx_event | output | 1 | Receive event, qualified by cfg_int_en |

## Verification
The assertions assume the deserializer never raises more than one of character, idle tick and break in the same cycle, and that configuration changes only while no traffic is pending. The stimulus drives each event in its own cycle and changes mode only with an empty buffer or under reset. The bench also assumes that wake characters are presented only in the multidrop modes whenever it expects them to steer the address logic. The idle-run closure relies on idle ticks arriving only between characters, and the stimulus never interleaves a tick with a character.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN  = 2'b00,
        MODE_MANUAL = 2'b01,
        MODE_RSVD   = 2'b10,
        MODE_AUTO   = 2'b11
    } rx_mode_e;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_EMPTY = 2'd1,
        ST_FILL  = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic ctrl;   // [7]
        logic addr;   // [6]
        logic match;  // [5]
        logic idle;   // [4]
        logic brk;    // [3]
        logic fe;     // [2]
        logic pe;     // [1]
        logic ovr;    // [0]
    } rx_stat_t;

    localparam int STAT_W = $bits(rx_stat_t);

endpackage

// File: rtl/rxb_addr_match.sv
module rxb_addr_match #(
    parameter int DATA_W   = 8,
    parameter int NUM_ADDR = 2
) (
    input  logic [DATA_W-1:0]   chr_data,
    input  logic [NUM_ADDR-1:0][DATA_W-1:0] addr_tab,
    output logic                hit,
    output logic                hit_first
);

    logic [NUM_ADDR-1:0] eq_vec;

    genvar g;
    generate
        for (g = 0; g < NUM_ADDR; g++) begin : g_cmp
            assign eq_vec[g] = (chr_data == addr_tab[g]);
        end
    endgenerate

    assign hit       = |eq_vec;
    assign hit_first = eq_vec[0];

endmodule

// File: rtl/rxb_idle_cnt.sv
module rxb_idle_cnt #(
    parameter int IDLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              restart,
    input  logic              arm,
    input  logic [IDLE_W-1:0] limit,
    output logic              expire
);

    logic [IDLE_W-1:0] run_cnt;
    logic [IDLE_W-1:0] run_inc;

    assign run_inc = run_cnt + 1'b1;
    assign expire  = tick && arm && (limit != '0) && (run_inc == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!arm || restart || expire) begin
            run_cnt <= '0;
        end else if (tick) begin
            run_cnt <= run_inc;
        end
    end

    AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (run_cnt == '0)); // R6

    AST_IDLE_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (run_cnt == '0)); // R6

endmodule

// File: rtl/rxb_ctrl_fsm.sv
module rxb_ctrl_fsm
    import rxb_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BUF_LEN = 8,
    parameter int CNT_W   = 4,
    parameter int IDX_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_valid,
    input  logic [DATA_W-1:0] chr_data,
    input  logic              chr_wake,
    input  logic              chr_ferr,
    input  logic              chr_perr,
    input  logic              brk_det,
    input  logic              ovr_det,
    input  logic              idle_expire,
    input  logic              addr_hit,
    input  logic              addr_first,
    input  rx_mode_e          mode,
    input  logic              int_en,
    input  logic              ctrl_en,
    input  logic [DATA_W-1:0] ctrl_char,
    output logic              fill_busy,
    output logic              wr_valid,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              cls_valid,
    output rx_stat_t          cls_status,
    output logic [CNT_W-1:0]  cls_count,
    output logic              rx_event
);

    rx_state_e        state, state_n;
    logic [CNT_W-1:0] fill, fill_n, fill_inc;
    logic             ovr_s, ovr_n;
    logic             addr_s, addr_n;
    logic             match_s, match_n;

    logic             do_wr, do_cls, keep_addr, take_rx, is_ctrl;
    logic [IDX_W-1:0] wr_i_n;
    logic [CNT_W-1:0] cnt_c;
    rx_stat_t         st_c;
    logic             is_auto, is_manual;

    assign is_auto   = (mode == MODE_AUTO);
    assign is_manual = (mode == MODE_MANUAL);
    assign fill_inc  = fill + 1'b1;
    assign is_ctrl   = ctrl_en && (chr_data == ctrl_char);
    assign fill_busy = (fill != '0);

    // next-state and action decode
    always_comb begin
        state_n   = state;
        fill_n    = fill;
        ovr_n     = ovr_s | ovr_det;
        addr_n    = addr_s;
        match_n   = match_s;
        do_wr     = 1'b0;
        wr_i_n    = '0;
        do_cls    = 1'b0;
        cnt_c     = fill;
        keep_addr = 1'b0;
        take_rx   = 1'b0;
        st_c       = '0;
        st_c.ovr   = ovr_s | ovr_det;
        st_c.addr  = is_auto ? 1'b1 : addr_s;
        st_c.match = is_auto & match_s;

        unique case (state)
            ST_HUNT: begin
                if (is_auto) begin
                    ovr_n = 1'b0;
                    if (chr_valid && chr_wake && addr_hit) begin
                        match_n = addr_first;   // T_ADDR_HIT
                        state_n = ST_EMPTY;
                    end
                end else begin
                    take_rx = 1'b1;
                end
            end
            ST_EMPTY, ST_FILL: begin
                take_rx = 1'b1;
            end
            default: begin
                state_n = ST_HUNT;
            end
        endcase

        if (take_rx) begin
            if (chr_valid && chr_wake && is_auto) begin
                do_cls = fill_busy;
                fill_n = '0;
                if (addr_hit) begin
                    match_n = addr_first;       // T_REHIT
                    state_n = ST_EMPTY;
                end else begin
                    state_n = ST_HUNT;          // T_ADDR_MISS
                end
            end else if (chr_valid && chr_wake && is_manual) begin
                do_cls    = fill_busy;
                keep_addr = 1'b1;
                addr_n    = 1'b1;
                do_wr     = 1'b1;
                wr_i_n    = '0;
                fill_n    = CNT_W'(1);
                state_n   = ST_FILL;
            end else if (chr_valid) begin
                do_wr  = 1'b1;
                wr_i_n = fill[IDX_W-1:0];
                if ((fill_inc == CNT_W'(BUF_LEN)) || is_ctrl || chr_ferr || chr_perr) begin
                    do_cls    = 1'b1;       // T_CLOSE
                    cnt_c     = fill_inc;
                    st_c.ctrl = is_ctrl;
                    st_c.fe   = chr_ferr;
                    st_c.pe   = chr_perr;
                    fill_n    = '0;
                    state_n   = ST_EMPTY;
                end else begin
                    fill_n  = fill_inc;     // T_FIRST_BYTE when empty
                    state_n = ST_FILL;
                end
            end else if (brk_det) begin
                do_cls   = 1'b1;
                st_c.brk = 1'b1;
                fill_n   = '0;
                state_n  = is_auto ? ST_HUNT : ST_EMPTY;   // T_BREAK_HUNT
            end else if (idle_expire) begin
                do_cls    = 1'b1;
                st_c.idle = 1'b1;
                fill_n    = '0;
                state_n   = ST_EMPTY;
            end
        end

        if (do_cls) begin
            ovr_n = 1'b0;
            if (!keep_addr) begin
                addr_n = 1'b0;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_HUNT;
            fill    <= '0;
            ovr_s   <= 1'b0;
            addr_s  <= 1'b0;
            match_s <= 1'b0;
        end else begin
            state   <= state_n;
            fill    <= fill_n;
            ovr_s   <= ovr_n;
            addr_s  <= addr_n;
            match_s <= match_n;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid   <= 1'b0;
            wr_idx     <= '0;
            wr_data    <= '0;
            cls_valid  <= 1'b0;
            cls_status <= '0;
            cls_count  <= '0;
            rx_event   <= 1'b0;
        end else begin
            wr_valid   <= do_wr;
            wr_idx     <= wr_i_n;
            wr_data    <= chr_data;
            cls_valid  <= do_cls;
            cls_status <= st_c;
            cls_count  <= cnt_c;
            rx_event   <= do_cls & int_en;
        end
    end

    AST_HUNT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT && is_auto) |=> !wr_valid); // R10

    AST_AUTO_ADDR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && chr_wake && is_auto) |=> !wr_valid); // R10

    AST_MATCH_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_valid && cls_status.match) |-> cls_status.addr); // R11

    AST_EVENT_WITH_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |-> cls_valid); // R13

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cls_valid |-> (cls_count <= CNT_W'(BUF_LEN))); // R3

    AST_ERR_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && !chr_wake && (chr_ferr || chr_perr) && state != ST_HUNT)
        |=> (cls_valid && (cls_status.fe || cls_status.pe))); // R5

    AST_BREAK_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_det && state != ST_HUNT) |=> (cls_valid && cls_status.brk)); // R7

endmodule

// File: rtl/uart_rxbuf_ctl.sv
module uart_rxbuf_ctl
    import rxb_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BUF_LEN = 8,
    parameter int IDLE_W  = 16,
    localparam int CNT_W  = $clog2(BUF_LEN + 1),
    localparam int IDX_W  = $clog2(BUF_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_valid,
    input  logic [DATA_W-1:0] chr_data,
    input  logic              chr_wake,
    input  logic              chr_ferr,
    input  logic              chr_perr,
    input  logic              idle_tick,
    input  logic              brk_det,
    input  logic              ovr_det,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_int_en,
    input  logic              cfg_ctrl_en,
    input  logic [DATA_W-1:0] cfg_ctrl_char,
    input  logic [DATA_W-1:0] cfg_addr1,
    input  logic [DATA_W-1:0] cfg_addr2,
    input  logic [IDLE_W-1:0] cfg_max_idle,
    output logic              wr_valid,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              cls_valid,
    output logic [STAT_W-1:0] cls_status,
    output logic [CNT_W-1:0]  cls_count,
    output logic              rx_event
);

    logic     hit, hit_first, idle_expire, fill_busy;
    rx_stat_t stat_w;
    logic [1:0][DATA_W-1:0] addr_tab;

    assign addr_tab[0] = cfg_addr1;
    assign addr_tab[1] = cfg_addr2;

    rxb_addr_match #(
        .DATA_W   (DATA_W),
        .NUM_ADDR (2)
    ) u_match (
        .chr_data  (chr_data),
        .addr_tab  (addr_tab),
        .hit       (hit),
        .hit_first (hit_first)
    );

    rxb_idle_cnt #(
        .IDLE_W (IDLE_W)
    ) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (idle_tick),
        .restart (chr_valid | brk_det),
        .arm     (fill_busy),
        .limit   (cfg_max_idle),
        .expire  (idle_expire)
    );

    rxb_ctrl_fsm #(
        .DATA_W  (DATA_W),
        .BUF_LEN (BUF_LEN),
        .CNT_W   (CNT_W),
        .IDX_W   (IDX_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .chr_valid   (chr_valid),
        .chr_data    (chr_data),
        .chr_wake    (chr_wake),
        .chr_ferr    (chr_ferr),
        .chr_perr    (chr_perr),
        .brk_det     (brk_det),
        .ovr_det     (ovr_det),
        .idle_expire (idle_expire),
        .addr_hit    (hit),
        .addr_first  (hit_first),
        .mode        (rx_mode_e'(cfg_mode)),
        .int_en      (cfg_int_en),
        .ctrl_en     (cfg_ctrl_en),
        .ctrl_char   (cfg_ctrl_char),
        .fill_busy   (fill_busy),
        .wr_valid    (wr_valid),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .cls_valid   (cls_valid),
        .cls_status  (stat_w),
        .cls_count   (cls_count),
        .rx_event    (rx_event)
    );

    assign cls_status = stat_w;

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chr_valid, idle_tick, brk_det})); // R14

    AST_WRITE_LAGS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(chr_valid)); // R14

endmodule

// File: tb/test_uart_rxbuf_ctl.sv
module test_uart_rxbuf_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W  = 8;
    localparam int BUF_LEN = 4;
    localparam int IDLE_W  = 8;
    localparam int CNT_W   = 3;
    localparam int IDX_W   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chr_valid, chr_wake, chr_ferr, chr_perr, idle_tick, brk_det, ovr_det;
    logic [DATA_W-1:0] chr_data;
    logic [1:0] cfg_mode;
    logic cfg_int_en, cfg_ctrl_en;
    logic [DATA_W-1:0] cfg_ctrl_char, cfg_addr1, cfg_addr2;
    logic [IDLE_W-1:0] cfg_max_idle;
    logic wr_valid, cls_valid, rx_event;
    logic [IDX_W-1:0] wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic [7:0] cls_status;
    logic [CNT_W-1:0] cls_count;

    uart_rxbuf_ctl #(
        .DATA_W (DATA_W), .BUF_LEN (BUF_LEN), .IDLE_W (IDLE_W)
    ) i_uart_rxbuf_ctl (
        .clk (clk), .rst_n (rst_n),
        .chr_valid (chr_valid), .chr_data (chr_data), .chr_wake (chr_wake),
        .chr_ferr (chr_ferr), .chr_perr (chr_perr),
        .idle_tick (idle_tick), .brk_det (brk_det), .ovr_det (ovr_det),
        .cfg_mode (cfg_mode), .cfg_int_en (cfg_int_en), .cfg_ctrl_en (cfg_ctrl_en),
        .cfg_ctrl_char (cfg_ctrl_char), .cfg_addr1 (cfg_addr1), .cfg_addr2 (cfg_addr2),
        .cfg_max_idle (cfg_max_idle),
        .wr_valid (wr_valid), .wr_idx (wr_idx), .wr_data (wr_data),
        .cls_valid (cls_valid), .cls_status (cls_status), .cls_count (cls_count),
        .rx_event (rx_event)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    string req_tag = "R1";
    logic [9:0]  wr_q[$];
    logic [11:0] cls_q[$];
    logic [9:0]  e_wr;
    logic [11:0] e_cls;

    task automatic exp_wr(input int idx, input int d);
        wr_q.push_back({2'(idx), 8'(d)});
    endtask

    task automatic exp_cls(input int st, input int cnt);
        cls_q.push_back({cfg_int_en, 8'(st), 3'(cnt)});
    endtask

    task automatic clear_in();
        chr_valid = 1'b0; chr_data = '0; chr_wake = 1'b0; chr_ferr = 1'b0;
        chr_perr = 1'b0; idle_tick = 1'b0; brk_det = 1'b0; ovr_det = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic w, input logic fe, input logic pe);
        chr_valid = 1'b1; chr_data = d; chr_wake = w; chr_ferr = fe; chr_perr = pe;
        @(negedge clk);
        clear_in();
    endtask

    task automatic pulse_idle();
        idle_tick = 1'b1; @(negedge clk); clear_in();
    endtask

    task automatic pulse_brk();
        brk_det = 1'b1; @(negedge clk); clear_in();
    endtask

    task automatic pulse_ovr();
        ovr_det = 1'b1; @(negedge clk); clear_in();
    endtask

    task automatic check(input logic ok, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req_tag, what, act, exp);
        end
    endtask

    // monitor: pops expected items as the design produces strobes
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid) begin
                if (wr_q.size() == 0) begin
                    check(1'b0, "unexpected write", {wr_idx, wr_data}, 0);
                end else begin
                    e_wr = wr_q.pop_front();
                    check({wr_idx, wr_data} == e_wr, "write idx/data", {wr_idx, wr_data}, e_wr);
                end
            end
            if (cls_valid) begin
                if (cls_q.size() == 0) begin
                    check(1'b0, "unexpected close", {rx_event, cls_status, cls_count}, 0);
                end else begin
                    e_cls = cls_q.pop_front();
                    check({rx_event, cls_status, cls_count} == e_cls, "close event/status/count",
                          {rx_event, cls_status, cls_count}, e_cls);
                end
            end else if (rx_event) begin
                check(1'b0, "event without close", 1, 0);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        clear_in();
        cfg_mode = 2'b00; cfg_int_en = 1'b1; cfg_ctrl_en = 1'b1; cfg_ctrl_char = 8'h0D;
        cfg_addr1 = 8'h5A; cfg_addr2 = 8'hA5; cfg_max_idle = 8'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        req_tag = "R1";
        check(!wr_valid, "wr_valid after reset", wr_valid, 0);
        check(!cls_valid, "cls_valid after reset", cls_valid, 0);
        check(!rx_event, "rx_event after reset", rx_event, 0);

        // R2 R3 R14: fill to full
        req_tag = "R3";
        exp_wr(0, 8'hA1); send(8'hA1, 0, 0, 0);
        exp_wr(1, 8'hA2); send(8'hA2, 0, 0, 0);
        exp_wr(2, 8'hA3); send(8'hA3, 0, 0, 0);
        exp_wr(3, 8'hA4); exp_cls(8'h00, 4); send(8'hA4, 0, 0, 0);

        req_tag = "R4";
        exp_wr(0, 8'h11); send(8'h11, 0, 0, 0);
        exp_wr(1, 8'h0D); exp_cls(8'h80, 2); send(8'h0D, 0, 0, 0);

        req_tag = "R5";
        exp_wr(0, 8'h22); send(8'h22, 0, 0, 0);
        exp_wr(1, 8'h33); exp_cls(8'h04, 2); send(8'h33, 0, 1, 0);
        exp_wr(0, 8'h44); exp_cls(8'h02, 1); send(8'h44, 0, 0, 1);

        req_tag = "R6";
        exp_wr(0, 8'h55); send(8'h55, 0, 0, 0);
        pulse_idle(); pulse_idle();
        exp_cls(8'h10, 1); pulse_idle();
        for (int i = 0; i < 4; i++) pulse_idle();   // empty buffer: no closure

        req_tag = "R7";
        exp_cls(8'h08, 0); pulse_brk();
        exp_wr(0, 8'h66); send(8'h66, 0, 0, 0);
        exp_cls(8'h08, 1); pulse_brk();

        req_tag = "R8";
        exp_wr(0, 8'h77); send(8'h77, 0, 0, 0);
        pulse_ovr();
        exp_wr(1, 8'h78); send(8'h78, 0, 0, 0);
        exp_wr(2, 8'h79); send(8'h79, 0, 0, 0);
        exp_wr(3, 8'h7A); exp_cls(8'h01, 4); send(8'h7A, 0, 0, 0);
        exp_wr(0, 8'h0D); exp_cls(8'h80, 1); send(8'h0D, 0, 0, 0);

        req_tag = "R13";
        cfg_int_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            exp_wr(i, 8'h01 + i); send(8'(8'h01 + i), 0, 0, 0);
        end
        exp_wr(3, 8'h04); exp_cls(8'h00, 4); send(8'h04, 0, 0, 0);
        cfg_int_en = 1'b1;

        req_tag = "R9";
        cfg_mode = 2'b01;
        exp_wr(0, 8'h10); send(8'h10, 0, 0, 0);
        exp_wr(1, 8'h11); send(8'h11, 0, 0, 0);
        exp_cls(8'h00, 2); exp_wr(0, 8'h42); send(8'h42, 1, 0, 0);
        exp_wr(1, 8'h12); send(8'h12, 0, 0, 0);
        exp_wr(2, 8'h13); send(8'h13, 0, 0, 0);
        exp_wr(3, 8'h14); exp_cls(8'h40, 4); send(8'h14, 0, 0, 0);
        exp_wr(0, 8'h43); send(8'h43, 1, 0, 0);
        exp_wr(1, 8'h15); exp_cls(8'h44, 2); send(8'h15, 0, 1, 0);

        // automatic multidrop, from reset
        @(negedge clk);
        rst_n = 1'b0; cfg_mode = 2'b11;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        req_tag = "R10";
        send(8'h01, 0, 0, 0);
        send(8'h33, 1, 0, 0);
        pulse_ovr();
        send(8'hA5, 1, 0, 0);

        req_tag = "R11";
        exp_wr(0, 8'h21); send(8'h21, 0, 0, 0);
        exp_wr(1, 8'h22); send(8'h22, 0, 0, 0);
        req_tag = "R12";
        exp_cls(8'h40, 2); send(8'h5A, 1, 0, 0);
        req_tag = "R11";
        exp_wr(0, 8'h23); send(8'h23, 0, 0, 0);
        exp_wr(1, 8'h0D); exp_cls(8'hE0, 2); send(8'h0D, 0, 0, 0);
        req_tag = "R12";
        send(8'h77, 1, 0, 0);
        send(8'h24, 0, 0, 0);
        send(8'h5A, 1, 0, 0);
        for (int i = 0; i < 3; i++) begin
            exp_wr(i, 8'h31 + i); send(8'(8'h31 + i), 0, 0, 0);
        end
        exp_wr(3, 8'h34); exp_cls(8'h60, 4); send(8'h34, 0, 0, 0);
        req_tag = "R7";
        exp_wr(0, 8'h35); send(8'h35, 0, 0, 0);
        exp_cls(8'h68, 1); pulse_brk();
        req_tag = "R10";
        send(8'h36, 0, 0, 0);
        pulse_idle(); pulse_idle(); pulse_idle();

        repeat (3) @(negedge clk);
        req_tag = "R14";
        check(wr_q.size() == 0, "pending writes left", wr_q.size(), 0);
        check(cls_q.size() == 0, "pending closes left", cls_q.size(), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule